// File: doc/BRIEF.md
# Buck-Boost Switch Phase Sequencer

This block is the digital controller of an inductor-based buck-boost converter that powers a smart-card contact. It reads two analog comparator flags: the inductor has reached peak current, and the output is above its target. It also reads a two-bit output-level code and a card-present flag. From these it decides, one clock at a time, which single group of power switches is enabled: the charge pair, the transfer pair, the inductor-clamp pair or the output pull-down. It also drives a select for the peak-current threshold, which follows the programmed level.

Regulation is hysteretic and works in phases.
- Charge: the inductor charges until peak current is reported.
- Transfer: a fixed-length phase hands the stored energy to the load.
- Clamp: if the output rises above target during transfer, the transfer pair drops at once and the clamp pair bleeds off the remaining inductor current.
- Wait: the block then waits with every switch off until the output falls below target, and charging restarts from zero inductor current.

A guard timer bounds a charge phase that never reaches peak current. Removing the card or selecting the off code stops conversion and enables the active pull-down.

Top module: `bbsw_sequencer`

## Requirements
- R1: While reset is asserted, and for two clocks after it is released, the outputs are in the idle state: en_pdn=1, en_chg=en_xfer=en_clamp=0, and ipk_sel=2'b00.
- R2: At most one of en_chg, en_xfer, en_clamp and en_pdn is 1 in any cycle.
- R3: Charging and hand-off to transfer:
  - With the card present and a non-off level, the idle state leads to one all-off cycle, then charge (en_chg=1).
  - The charge phase ends on the first cycle the synchronized peak flag is seen. One all-off cycle follows, then en_xfer=1.
- R4: The transfer phase lasts exactly XFER_CYC cycles when the output stays below target. It is then followed by one all-off cycle and a new charge phase.
- R5: Cutting off the transfer:
  - When the synchronized above-target flag is seen during transfer, the very next cycle has en_xfer=0 and en_clamp=1, with no all-off cycle between them.
  - This takes priority over the end of the transfer timer.
  - Clamp lasts CLAMP_CYC cycles, after which all switches are off.
- R6: After clamp, all switches stay off while the output is above target. The cycle after the synchronized flag is seen low, en_chg=1.
- R7: A charge phase that lasts GUARD_CYC cycles without a peak flag ends. One all-off cycle follows, then a fresh charge phase. This repeats for as long as no peak flag arrives.
- R8: Stopping conversion:
  - When card_in=0 or lvl_sel=2'b00, the next cycle has en_chg, en_xfer and en_clamp all 0.
  - From any conversion state, one all-off cycle follows, then en_pdn=1, held while the condition lasts.
  - This takes priority over every other event.
- R9: The level codes are 2'b00 off, 2'b01 1.8 V, 2'b10 3.0 V and 2'b11 5.0 V. ipk_sel equals lvl_sel delayed by one clock, and it follows the code even when no card is present.
- R10: Each comparator flag passes through two synchronizing flops. A flag driven before clock edge k acts on the state that takes effect at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ipk_raw | input | 1 | Peak-current comparator flag, asynchronous |
| vhi_raw | input | 1 | Output-above-target comparator flag, asynchronous |
| lvl_sel | input | 2 | Output level code: 00 off, 01 1.8 V, 10 3.0 V, 11 5.0 V |
| card_in | input | 1 | Card present |
| en_chg | output | 1 | Charge pair enable |
| en_xfer | output | 1 | Transfer pair enable |
| en_clamp | output | 1 | Inductor-clamp pair enable |
| en_pdn | output | 1 | Output pull-down enable |
| ipk_sel | output | 2 | Peak-current threshold select, follows the level code |

## Verification
Two events can land on the same clock, and each pair has a fixed winner.

The first pair is the above-target cut-off and the expiry of the transfer timer. The bench provokes it by raising the output flag exactly two cycles before the last transfer cycle. The clamp must then appear directly, with no all-off cycle and no return to charge.

The second pair is the cut-off and a card removal. The bench pulls the card in the same cycle in which the synchronized flag first becomes visible during transfer. The result must be the all-off cycle and then the pull-down, with the clamp never enabled.

The reference model resolves both collisions by the priority order stated in R5 and R8, and it is compared against all outputs on every clock.

// File: rtl/bbsw_pkg.sv
package bbsw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DCHG = 3'd1,
    PH_CHG  = 3'd2,
    PH_DXFR = 3'd3,
    PH_XFR  = 3'd4,
    PH_CLMP = 3'd5,
    PH_WAIT = 3'd6,
    PH_DPDN = 3'd7
  } phase_t;
endpackage

// File: rtl/bbsw_sync.sv
module bbsw_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= 2'b00;
      else        sh <= {sh[0], d[i]};
    end
    assign q[i] = sh[1];
  end
endmodule

// File: rtl/bbsw_timer.sv
module bbsw_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  logic cnt_en;
  assign cnt_en = clr || (cnt != {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= clr ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/bbsw_fsm.sv
module bbsw_fsm
  import bbsw_pkg::*;
#(
  parameter int CW        = 8,
  parameter int XFER_CYC  = 45,
  parameter int GUARD_CYC = 200,
  parameter int CLAMP_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ipk,
  input  logic          vhi,
  input  logic [CW-1:0] cnt,
  output logic          clr,
  output logic          en_chg,
  output logic          en_xfer,
  output logic          en_clamp,
  output logic          en_pdn
);
  localparam logic [CW-1:0] XFER_LAST  = CW'(XFER_CYC - 1);
  localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_CYC - 1);
  localparam logic [CW-1:0] CLAMP_LAST = CW'(CLAMP_CYC - 1);

  phase_t st, st_nx;

  always_comb begin
    st_nx = st;
    if (!run) begin
      st_nx = (st == PH_IDLE || st == PH_DPDN) ? PH_IDLE : PH_DPDN;
    end else begin
      case (st)
        PH_IDLE: st_nx = PH_DCHG;
        PH_DCHG: st_nx = PH_CHG;
        PH_CHG: begin
          if (ipk)                     st_nx = PH_DXFR;
          else if (cnt == GUARD_LAST)  st_nx = PH_DCHG;
        end
        PH_DXFR: st_nx = PH_XFR;
        PH_XFR: begin
          if (vhi)                     st_nx = PH_CLMP;
          else if (cnt == XFER_LAST)   st_nx = PH_DCHG;
        end
        PH_CLMP: if (cnt == CLAMP_LAST) st_nx = PH_WAIT;
        PH_WAIT: if (!vhi)              st_nx = PH_CHG;
        PH_DPDN: st_nx = PH_IDLE;
        default: st_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PH_IDLE;
    else        st <= st_nx;
  end

  assign clr      = (st_nx != st);
  assign en_chg   = (st == PH_CHG);
  assign en_xfer  = (st == PH_XFR);
  assign en_clamp = (st == PH_CLMP);
  assign en_pdn   = (st == PH_IDLE);
endmodule

// File: rtl/bbsw_sequencer.sv
module bbsw_sequencer #(
  parameter int XFER_CYC  = 45,
  parameter int GUARD_CYC = 200,
  parameter int CLAMP_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ipk_raw,
  input  logic       vhi_raw,
  input  logic [1:0] lvl_sel,
  input  logic       card_in,
  output logic       en_chg,
  output logic       en_xfer,
  output logic       en_clamp,
  output logic       en_pdn,
  output logic [1:0] ipk_sel
);
  localparam int MAX_A = (XFER_CYC > GUARD_CYC) ? XFER_CYC : GUARD_CYC;
  localparam int MAX_C = (MAX_A > CLAMP_CYC) ? MAX_A : CLAMP_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  logic [1:0]    rst_q;
  logic          rst_i;
  logic [1:0]    cmp_s;
  logic          ipk_s, vhi_s;
  logic          run;
  logic          clr;
  logic [CW-1:0] cnt;
  logic          sel_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  bbsw_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({vhi_raw, ipk_raw}),
    .q     (cmp_s)
  );
  assign ipk_s = cmp_s[0];
  assign vhi_s = cmp_s[1];

  assign run = card_in && (lvl_sel != 2'b00);

  bbsw_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_i),
    .clr   (clr),
    .cnt   (cnt)
  );

  bbsw_fsm #(
    .CW        (CW),
    .XFER_CYC  (XFER_CYC),
    .GUARD_CYC (GUARD_CYC),
    .CLAMP_CYC (CLAMP_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_i),
    .run      (run),
    .ipk      (ipk_s),
    .vhi      (vhi_s),
    .cnt      (cnt),
    .clr      (clr),
    .en_chg   (en_chg),
    .en_xfer  (en_xfer),
    .en_clamp (en_clamp),
    .en_pdn   (en_pdn)
  );

  assign sel_ld = (ipk_sel != lvl_sel);
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      ipk_sel <= 2'b00;
    else if (sel_ld) ipk_sel <= lvl_sel;
  end
endmodule

// File: rtl/bbsw_checker.sv
module bbsw_checker (
  input logic       clk,
  input logic       rst_i,
  input logic       ipk_s,
  input logic       vhi_s,
  input logic       card_in,
  input logic [1:0] lvl_sel,
  input logic       en_chg,
  input logic       en_xfer,
  input logic       en_clamp,
  input logic       en_pdn
);
  logic live;
  assign live = card_in && (lvl_sel != 2'b00);

  AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({en_chg, en_xfer, en_clamp, en_pdn})); // R2

  AST_CHG_GAP: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(en_chg) |-> !(en_xfer || en_clamp || en_pdn)); // R3

  AST_PEAK_ENDS_CHG: assert property (@(posedge clk) disable iff (!rst_i)
    (en_chg && ipk_s && live) |=> !(en_chg || en_xfer || en_clamp || en_pdn)); // R3

  AST_CUT_TO_CLAMP: assert property (@(posedge clk) disable iff (!rst_i)
    (en_xfer && vhi_s && live) |=> (en_clamp && !en_xfer)); // R5

  AST_STOP_CONVERT: assert property (@(posedge clk) disable iff (!rst_i)
    !live |=> !(en_chg || en_xfer || en_clamp)); // R8
endmodule

bind bbsw_sequencer bbsw_checker u_chk (
  .clk      (clk),
  .rst_i    (rst_i),
  .ipk_s    (ipk_s),
  .vhi_s    (vhi_s),
  .card_in  (card_in),
  .lvl_sel  (lvl_sel),
  .en_chg   (en_chg),
  .en_xfer  (en_xfer),
  .en_clamp (en_clamp),
  .en_pdn   (en_pdn)
);

// File: tb/tb_bbsw_sequencer.sv
module tb_bbsw_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int TX = 6;
  localparam int TG = 12;
  localparam int TC = 3;
  // model phase codes
  localparam int S_IDLE = 0, S_DCHG = 1, S_CHG = 2, S_DXFR = 3;
  localparam int S_XFR = 4, S_CLMP = 5, S_WAIT = 6, S_DPDN = 7;

  logic clk = 1'b0;
  logic rst_n, ipk_raw, vhi_raw, card_in;
  logic [1:0] lvl_sel;
  logic en_chg, en_xfer, en_clamp, en_pdn;
  logic [1:0] ipk_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  bbsw_sequencer #(.XFER_CYC(TX), .GUARD_CYC(TG), .CLAMP_CYC(TC)) dut (
    .clk(clk), .rst_n(rst_n), .ipk_raw(ipk_raw), .vhi_raw(vhi_raw),
    .lvl_sel(lvl_sel), .card_in(card_in), .en_chg(en_chg), .en_xfer(en_xfer),
    .en_clamp(en_clamp), .en_pdn(en_pdn), .ipk_sel(ipk_sel)
  );

  int m_st, m_cnt, m_rel, m_nx;
  bit m_s1i, m_s2i, m_s1v, m_s2v, m_run;
  logic [1:0] m_sel;
  int vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model: advances once per rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_st = S_IDLE; m_cnt = 0; m_rel = 0; m_sel = 2'b00;
      m_s1i = 0; m_s2i = 0; m_s1v = 0; m_s2v = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      m_run = card_in && (lvl_sel != 2'b00);
      m_nx = m_st;
      if (!m_run) m_nx = (m_st == S_IDLE || m_st == S_DPDN) ? S_IDLE : S_DPDN;
      else begin
        case (m_st)
          S_IDLE: m_nx = S_DCHG;
          S_DCHG: m_nx = S_CHG;
          S_CHG:  if (m_s2i) m_nx = S_DXFR; else if (m_cnt == TG-1) m_nx = S_DCHG;
          S_DXFR: m_nx = S_XFR;
          S_XFR:  if (m_s2v) m_nx = S_CLMP; else if (m_cnt == TX-1) m_nx = S_DCHG;
          S_CLMP: if (m_cnt == TC-1) m_nx = S_WAIT;
          S_WAIT: if (!m_s2v) m_nx = S_CHG;
          default: m_nx = S_IDLE;
        endcase
      end
      m_cnt = (m_nx != m_st) ? 0 : m_cnt + 1;
      m_st = m_nx;
      m_s2i = m_s1i; m_s1i = ipk_raw;
      m_s2v = m_s1v; m_s1v = vhi_raw;
      m_sel = lvl_sel;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      logic [5:0] got, exp;
      got = {en_chg, en_xfer, en_clamp, en_pdn, ipk_sel};
      exp = {m_st == S_CHG, m_st == S_XFR, m_st == S_CLMP, m_st == S_IDLE, m_sel};
      vectors++;
      if (got !== exp) begin
        fails++;
        $display("FAIL %s: chg/xfer/clamp/pdn/sel got %b expected %b (t=%0t)", cur_req, got, exp, $time);
      end
      vectors++;
      if ($countones({en_chg, en_xfer, en_clamp, en_pdn}) > 1) begin
        fails++;
        $display("FAIL R2: groups got %b expected at most one set", got[5:2]);
      end
      if (cycles > 5000) begin
        fails++;
        $display("FAIL watchdog: cycles got %0d expected below 5000", cycles);
        finish_run();
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ipk();
    ipk_raw = 1'b1; cyc(1); ipk_raw = 1'b0;
  endtask

  task automatic wait_st(input int s);
    int k = 0;
    while (m_st != s && k < 200) begin @(negedge clk); k++; end
    if (k >= 200) begin
      fails++; vectors++;
      $display("FAIL %s: phase got %0d expected %0d", cur_req, m_st, s);
    end
  endtask

  initial begin
    rst_n = 1'b0; ipk_raw = 0; vhi_raw = 0; card_in = 0; lvl_sel = 2'b00;
    cur_req = "R1";
    cyc(3); rst_n = 1'b1; cyc(5);
    // code follows with no card present, no conversion starts
    cur_req = "R9";
    lvl_sel = 2'b10; cyc(4);
    // start and peak hand-off
    cur_req = "R3";
    card_in = 1'b1; lvl_sel = 2'b01; cyc(4);
    pulse_ipk();
    cur_req = "R10"; cyc(3);
    // full-length transfer then back to charge
    cur_req = "R4"; cyc(TX + 6);
    // guard expiry repeats
    cur_req = "R7"; cyc(2*TG + 6);
    // cut-off into clamp, then wait
    cur_req = "R5";
    pulse_ipk(); wait_st(S_XFR); vhi_raw = 1'b1; cyc(TC + 6);
    cur_req = "R6"; cyc(4); vhi_raw = 1'b0; cyc(6);
    // collision: cut-off on the last transfer cycle (R5 wins over R4 expiry)
    cur_req = "R5";
    pulse_ipk(); wait_st(S_XFR);
    while (m_cnt != TX-3) @(negedge clk);
    vhi_raw = 1'b1; cyc(TC + 4); vhi_raw = 1'b0; cyc(5);
    // collision: card pulled as cut-off becomes visible (R8 wins)
    cur_req = "R8";
    pulse_ipk(); wait_st(S_XFR); vhi_raw = 1'b1;
    while (!m_s2v) @(negedge clk);
    card_in = 1'b0; cyc(1);
    vectors++;
    if (en_clamp !== 1'b0 || en_xfer !== 1'b0) begin
      fails++;
      $display("FAIL R8: xfer/clamp got %b%b expected 00", en_xfer, en_clamp);
    end
    cyc(5); vhi_raw = 1'b0;
    cur_req = "R9";
    card_in = 1'b1; lvl_sel = 2'b11; cyc(6);
    // off code while charging
    cur_req = "R8";
    lvl_sel = 2'b00; cyc(6);
    cur_req = "R3";
    lvl_sel = 2'b11; cyc(5); pulse_ipk(); cyc(TX + 8);
    finish_run();
  end
endmodule